// File: doc/BRIEF.md
# Serial Receive Port Controller

This block sits between a demodulator and a serial payload consumer. While the receive-enable input is high, it takes demodulated bits one at a time from an upstream valid/ready stream. The first bit of a frame carries a start-of-header flag. The block gathers a fixed-size header made of a length field and a check field, then runs a CCITT CRC-16 over the length field. A frame whose header passes has its payload forwarded bit by bit to a downstream valid/ready stream with no added latency. A transfer strobe serves as the receive data clock, and a modem-ready level frames the payload.

Both streams follow the usual valid/ready rules. A bit moves when valid and ready are high together at a rising clock edge. Upstream must hold `in_bit` and `in_sof` steady while `in_valid` is high and `in_ready` is low. During the payload, downstream back-pressure on `out_ready` passes straight through to `in_ready`. During the header and while waiting for a frame, the block is always ready.

Dropping receive-enable puts the whole path into standby. Nothing is accepted, and an open frame is abandoned at once. The block has no transmit side, so a separate transmit path can run at the same time.

Top module: `rx_port_ctrl`

## Requirements
- R1: After reset `md_rdy`, `out_valid` and `out_clk` are low and the block waits for a start-of-header bit.
- R2: While `rx_en` is low, `in_ready` and `md_rdy` are low and no bit is taken in.
- R3: When enabled and waiting, bits without `in_sof` set are accepted and discarded, with `out_valid` and `md_rdy` staying low.
- R4: A header is LEN_W length bits followed by 16 check bits. Both fields arrive least-significant bit first, and the first length bit is the one flagged by `in_sof`.
- R5: The CRC starts from 16'hFFFF. For each length bit b it computes `fb = crc[15]^b; crc = {crc[14:0],0} ^ (fb ? 16'h1021 : 0)`. The header passes when the check field equals `~crc`.
- R6: On a passing header with a nonzero length, `md_rdy` is high in the cycle after the last check bit is accepted.
- R7: On a failing header, `md_rdy` stays low and no payload is output, and the block returns to waiting for a start-of-header bit.
- R8: During the payload, `out_valid` follows `in_valid` and `out_bit` equals `in_bit` in the same cycle. `out_clk` is high exactly on cycles where a bit is transferred, and bit order is preserved.
- R9: During the payload `in_ready` equals `out_ready`; a stalled bit stays presented with `out_clk` low.
- R10: After the number of payload bits given by the length field has been transferred, `md_rdy` and `out_valid` are low from the next cycle on.
- R11: A passing header with a length of zero never raises `md_rdy`.
- R12: Lowering `rx_en` in mid-payload clears `md_rdy` and `out_valid` in the same cycle. After re-enabling, only a new start-of-header bit begins a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable; low means standby |
| in_valid | input | 1 | Upstream demodulated bit valid |
| in_ready | output | 1 | Block can accept an upstream bit |
| in_sof | input | 1 | Marks the first header bit |
| in_bit | input | 1 | Upstream demodulated bit |
| out_valid | output | 1 | Payload bit valid |
| out_ready | input | 1 | Downstream can take a payload bit |
| out_bit | output | 1 | Payload bit, LSB first |
| out_clk | output | 1 | Receive data clock strobe, one per transferred bit |
| md_rdy | output | 1 | Modem ready; high while a checked payload is flowing |

## Verification
The bench builds the block with LEN_W = 8, so a header is 24 bits and the tests stay short. With that setting, payloads from zero to 32 bits cover the zero-length, one-bit and multi-word cases, along with the exact cycle in which the final bit closes the frame. A deliberately corrupted check field, pre-frame garbage, stalled downstream cycles and an enable drop in mid-payload are all reachable within a few hundred cycles each.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY} rx_state_e;

  localparam int          CRC_W    = 16;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  endfunction
endpackage

// File: rtl/rxp_crc16.sv
module rxp_crc16
  import rxp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        first,
  input  logic        bit_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  crc_q <= CRC_INIT;
    else if (en) crc_q <= crc_step(first ? CRC_INIT : crc_q, bit_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/rxp_down_cnt.sv
module rxp_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (load)                      cnt_q <= load_val;
    else if (dec && (cnt_q != '0))      cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == W'(1));
endmodule

// File: rtl/rxp_hdr_shift.sv
module rxp_hdr_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         bit_i,
  output logic [W-1:0] sr_o
);
  logic [W-1:0] sr_q;

  // LSB-first arrival: new bit enters at the top and moves down.
  always_ff @(posedge clk) begin
    if (!rst_n)  sr_q <= '0;
    else if (en) sr_q <= {bit_i, sr_q[W-1:1]};
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/rx_port_ctrl.sv
module rx_port_ctrl
  import rxp_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_sof,
  input  logic in_bit,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic out_clk,
  output logic md_rdy
);
  localparam int HDR_W = LEN_W + CRC_W;
  localparam int HC_W  = $clog2(HDR_W + 1);

  rx_state_e   state_q, state_d;
  logic        acc, start, in_hdr, hdr_last, crc_en, pass, pay_acc;
  logic [HDR_W-1:0] sr, word;
  logic [LEN_W-1:0] len_f;
  logic [CRC_W-1:0] chk_f, crc;
  logic [HC_W-1:0]  hcnt;
  logic             hlast;
  logic [LEN_W-1:0] pcnt;
  logic             plast;

  always_comb begin
    if (!rx_en)                in_ready = 1'b0;
    else if (state_q == ST_PAY) in_ready = out_ready;
    else                        in_ready = 1'b1;
  end

  assign acc      = in_valid && in_ready;
  assign start    = (state_q == ST_IDLE) && acc && in_sof;
  assign in_hdr   = (state_q == ST_HDR) && acc;
  assign hdr_last = in_hdr && hlast;
  assign crc_en   = start || (in_hdr && (hcnt > HC_W'(CRC_W)));
  assign pay_acc  = (state_q == ST_PAY) && acc;

  assign word  = {in_bit, sr[HDR_W-1:1]};
  assign len_f = word[LEN_W-1:0];
  assign chk_f = word[HDR_W-1:LEN_W];
  assign pass  = (chk_f == ~crc);

  rxp_hdr_shift #(.W(HDR_W)) u_sr (
    .clk(clk), .rst_n(rst_n), .en(start || in_hdr), .bit_i(in_bit), .sr_o(sr)
  );

  rxp_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .en(crc_en), .first(start), .bit_i(in_bit), .crc_o(crc)
  );

  rxp_down_cnt #(.W(HC_W)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .load(start), .load_val(HC_W'(HDR_W - 1)),
    .dec(in_hdr), .cnt_o(hcnt), .last_o(hlast)
  );

  rxp_down_cnt #(.W(LEN_W)) u_pcnt (
    .clk(clk), .rst_n(rst_n), .load(hdr_last && pass), .load_val(len_f),
    .dec(pay_acc), .cnt_o(pcnt), .last_o(plast)
  );

  always_comb begin
    state_d = state_q;
    if (!rx_en) state_d = ST_IDLE;
    else begin
      case (state_q)
        ST_IDLE: if (start) state_d = ST_HDR;
        ST_HDR:  if (hdr_last) state_d = (pass && (len_f != '0)) ? ST_PAY : ST_IDLE;
        ST_PAY:  if (pay_acc && plast) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign md_rdy    = rx_en && (state_q == ST_PAY);
  assign out_valid = md_rdy && in_valid;
  assign out_bit   = in_bit;
  assign out_clk   = out_valid && out_ready;

  logic unused_pcnt;
  assign unused_pcnt = ^pcnt;
endmodule

// File: rtl/rx_port_ctrl_chk.sv
module rx_port_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic in_valid,
  input logic in_ready,
  input logic in_sof,
  input logic in_bit,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic out_clk,
  input logic md_rdy
);
  a_r2_standby: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> (!in_ready && !md_rdy));

  a_r8_out_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (md_rdy && in_valid));

  a_r9_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    md_rdy |-> (in_ready == out_ready));

  a_r6_rise_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(md_rdy) |-> $past(in_valid && in_ready));

  a_r8_clk_on_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    out_clk |-> (out_ready && md_rdy && in_ready));

  a_r12_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_en) |-> (!md_rdy && !out_valid));

  logic unused;
  assign unused = in_sof ^ in_bit ^ out_bit;
endmodule

bind rx_port_ctrl rx_port_ctrl_chk u_chk (.*);

// File: tb/rx_port_ctrl_test.sv
module rx_port_ctrl_test;
  localparam int CLK_P = 10;
  localparam int LW    = 8;

  // entry: [41:34] length, [33] corrupt check, [32] stall each bit, [31:0] payload
  localparam int NV = 6;
  localparam logic [41:0] VEC [NV] = '{
    {8'd5,  1'b0, 1'b0, 32'h0000_0015},
    {8'd12, 1'b0, 1'b1, 32'h0000_0A5C},
    {8'd9,  1'b1, 1'b0, 32'h0000_01FF},
    {8'd32, 1'b0, 1'b0, 32'hDEAD_BEEF},
    {8'd1,  1'b0, 1'b1, 32'h0000_0001},
    {8'd0,  1'b0, 1'b0, 32'h0000_0000}
  };

  logic clk = 0, rst_n = 0, rx_en = 0;
  logic in_valid = 0, in_sof = 0, in_bit = 0, out_ready = 1;
  logic in_ready, out_valid, out_bit, out_clk, md_rdy;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  rx_port_ctrl #(.LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_bit(in_bit), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit), .out_clk(out_clk), .md_rdy(md_rdy)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [LW-1:0] len);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < LW; i++) begin
      logic fb = c[15] ^ len[i];
      c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0);
    end
    return c;
  endfunction

  // called just after a negedge; returns just after the next negedge following acceptance
  task automatic put(input logic sof, input logic b);
    in_valid = 1; in_sof = sof; in_bit = b;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; in_sof = 0;
  endtask

  task automatic send_header(input logic [LW-1:0] len, input bit bad);
    logic [15:0] cf;
    cf = ~ref_crc(len) ^ {15'b0, bad};
    put(1'b1, len[0]);
    for (int i = 1; i < LW; i++) put(1'b0, len[i]);
    for (int i = 0; i < 16; i++) put(1'b0, cf[i]);
  endtask

  task automatic pay_bit(input logic b, input bit stall, input bit is_last);
    in_valid = 1; in_bit = b;
    if (stall) begin
      out_ready = 0; #1;
      chk(in_ready == 0 && out_valid == 1 && out_clk == 0, "R9", "stall hold", int'(out_clk), 0);
      @(negedge clk);
      out_ready = 1;
    end
    #1;
    chk(out_clk == 1 && out_bit == b, "R8", "payload bit", int'(out_bit), int'(b));
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    #1;
    if (is_last) chk(md_rdy == 0, "R10", "ready after last bit", int'(md_rdy), 0);
    else         chk(md_rdy == 1, "R8",  "ready mid payload",   int'(md_rdy), 1);
  endtask

  task automatic run_frame(input logic [41:0] v);
    logic [7:0] len = v[41:34];
    bit bad = v[33], st = v[32];
    logic [31:0] p = v[31:0];
    send_header(len[LW-1:0], bad);
    #1;
    // R4 R5 header decode, R6 pass timing, R7 fail, R11 zero length
    chk(md_rdy == (!bad && len != 0), "R6", "md_rdy after header", int'(md_rdy), int'(!bad && len != 0));
    if (!bad && len != 0) begin
      for (int i = 0; i < int'(len); i++) pay_bit(p[i], st, i == int'(len) - 1);
    end else begin
      in_valid = 1; in_bit = 1; #1;
      chk(out_valid == 0 && md_rdy == 0, "R7", "no output after reject", int'(out_valid), 0);
      @(negedge clk); in_valid = 0;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(md_rdy == 0 && out_valid == 0 && out_clk == 0, "R1", "reset outputs", int'(md_rdy), 0);
    rst_n = 1;
    @(negedge clk);
    in_valid = 1; in_sof = 1; #1;
    chk(in_ready == 0 && md_rdy == 0, "R2", "standby no accept", int'(in_ready), 0);
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready == 0, "R2", "standby held", int'(in_ready), 0);
    in_valid = 0; in_sof = 0;
    rx_en = 1;
    @(negedge clk);

    // R3: garbage before a frame
    for (int i = 0; i < 4; i++) put(1'b0, 1'b1);
    #1;
    chk(md_rdy == 0 && out_valid == 0, "R3", "pre-frame bits discarded", int'(md_rdy), 0);

    for (int k = 0; k < NV; k++) run_frame(VEC[k]);

    // R12: enable drop in mid-payload
    send_header(8'd6, 1'b0);
    pay_bit(1'b1, 1'b0, 1'b0);
    pay_bit(1'b0, 1'b0, 1'b0);
    in_valid = 1; in_bit = 1;
    rx_en = 0; #1;
    chk(md_rdy == 0 && out_valid == 0 && in_ready == 0, "R12", "drop clears", int'(md_rdy), 0);
    @(negedge clk);
    in_valid = 0;
    rx_en = 1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) put(1'b0, 1'b0);
    #1;
    chk(md_rdy == 0, "R12", "no resume without sof", int'(md_rdy), 0);
    run_frame({8'd3, 1'b0, 1'b0, 32'h0000_0005});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule